// File: doc/BRIEF.md
# Sector Write-Protection Checker

This block rules on every program or erase request aimed at a 16 MB flash array built from 256 sectors of 64 KB. A sector is blocked either by a power-of-two block-protect range anchored at the low or high end of the array, or by its own volatile lock bit. A request that is turned down raises a sticky protection-error flag, and that flag stays up until a clear command arrives. The range settings live in a small status register. When that register's write-disable bit is set, the active-low write-protect pin can freeze it.

Each request is presented for one clock cycle with its kind and its 24-bit byte address. One cycle later the block raises exactly one of its allow and deny outputs. A status write, a lock write or a clear in the same cycle as a request takes effect only for later requests. A power-up reset returns all protection state to the unprotected condition.

Top module: `sector_wp_checker`

## Requirements
- R1: With a block-protect value of 0, no sector is protected by the range.
- R2: With the top/bottom select at 1 (bottom), a nonzero block-protect value n protects sectors 0 through 2^(n-1)-1. Values 9 to 15 protect all 256 sectors.
- R3: With the top/bottom select at 0 (top), a nonzero value n protects the highest 2^(n-1) sectors, ending at sector 255. Values 9 to 15 protect all sectors.
- R4: The target sector is address bits [23:16]. While a sector's lock bit is 1, a program (kind 0), subsector erase (kind 1) or sector erase (kind 2) to that sector is denied.
- R5: Once a sector's lock-down bit is set, a later lock write leaves that sector's lock bit unchanged. The lock-down bit itself clears only on reset.
- R6: A status write is ignored while the stored write-disable bit is 1 and wp_n is 0. Otherwise it loads the block-protect value, the top/bottom select and the write-disable bit.
- R7: A bulk erase (kind 3) is denied if the block-protect value is nonzero or if any lock bit is set.
- R8: A denied request sets prot_err in the same cycle that op_deny rises. prot_err stays set until clr_flags is seen. When a deny and a clear occur together, the set takes priority.
- R9: One cycle after op_valid, exactly one of op_allow and op_deny is 1. In every other cycle both are 0. A request is judged on the state held before any same-cycle write.
- R10: After reset, the block-protect value, the top/bottom select, the write-disable bit, all lock and lock-down bits, and prot_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| op_valid | input | 1 | A request is present this cycle |
| op_kind | input | 2 | 0 program, 1 subsector erase, 2 sector erase, 3 bulk erase |
| op_addr | input | 24 | Byte address of the request |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_bp | input | 4 | New block-protect value |
| sr_wr_tb | input | 1 | New top/bottom select (1 selects bottom) |
| sr_wr_srwd | input | 1 | New status write-disable bit |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| lk_wr_en | input | 1 | Lock register write strobe |
| lk_wr_sector | input | 8 | Sector that the lock write targets |
| lk_wr_lock | input | 1 | New lock bit value |
| lk_wr_down | input | 1 | Sets the lock-down bit when 1 |
| clr_flags | input | 1 | Clears prot_err |
| op_allow | output | 1 | Request allowed, one cycle after op_valid |
| op_deny | output | 1 | Request denied, one cycle after op_valid |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 256 sectors and a 4-bit protect field. With these values every protect value falls within reach, from 1 (a single sector) through 8 (half the array) and on to the saturating values 9 and above. Both ends of the array are probed at the exact sector where protection stops, for example sectors 127/128 and 251/252. Lock tests use sectors at both ends and in the middle. They also cover the sticky lock-down, the pin-frozen status register, and bulk erase against each of the two protection mechanisms.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SSE  = 2'd1,
        OP_SE   = 2'd2,
        OP_BULK = 2'd3
    } wpc_op_e;
endpackage

// File: rtl/wpc_range.sv
module wpc_range #(
    parameter int SECTOR_BITS = 8,
    parameter int BP_W        = 4
) (
    input  logic [BP_W-1:0]        bp,
    input  logic                   tb,
    input  logic [SECTOR_BITS-1:0] sector,
    output logic                   in_range,
    output logic                   any_range
);
    logic [BP_W-1:0]        shift;
    logic [SECTOR_BITS-1:0] tag;

    always_comb begin
        shift     = bp - BP_W'(1);
        // bottom: count from sector 0; top: count from the last sector
        tag       = tb ? sector : ~sector;
        any_range = (bp != '0);
        if (bp == '0)
            in_range = 1'b0;
        else if (int'(shift) >= SECTOR_BITS)
            in_range = 1'b1;
        else
            in_range = ((tag >> shift) == '0);
    end

    // R1: a zero field never protects anything
    always_comb begin
        if (bp == '0)
            p_zero_free_r1: assert (!in_range);
    end
endmodule

// File: rtl/wpc_lock_bank.sv
module wpc_lock_bank #(
    parameter int SECTOR_BITS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SECTOR_BITS-1:0] wr_sector,
    input  logic                   wr_lock,
    input  logic                   wr_down,
    input  logic [SECTOR_BITS-1:0] rd_sector,
    output logic                   rd_lock,
    output logic                   any_lock
);
    localparam int NSEC = 1 << SECTOR_BITS;

    typedef struct packed {
        logic [NSEC-1:0] lock;
        logic [NSEC-1:0] down;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (!bank_q.down[wr_sector])
                bank_d.lock[wr_sector] = wr_lock;
            if (wr_down)
                bank_d.down[wr_sector] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_lock  = bank_q.lock[rd_sector];
    assign any_lock = |bank_q.lock;

    // R5: lock-down bits only accumulate while out of reset
    p_down_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_q.down) >= $past($countones(bank_q.down)));

    // R5: a write to a locked-down sector leaves its lock bit alone
    p_lock_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_q.down[wr_sector])
        |=> (bank_q.lock[$past(wr_sector)] == $past(bank_q.lock[wr_sector])));
endmodule

// File: rtl/sector_wp_checker.sv
module sector_wp_checker #(
    parameter int ADDR_W      = 24,
    parameter int SECTOR_BITS = 8,
    parameter int BP_W        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [1:0]             op_kind,
    input  logic [ADDR_W-1:0]      op_addr,
    input  logic                   sr_wr_en,
    input  logic [BP_W-1:0]        sr_wr_bp,
    input  logic                   sr_wr_tb,
    input  logic                   sr_wr_srwd,
    input  logic                   wp_n,
    input  logic                   lk_wr_en,
    input  logic [SECTOR_BITS-1:0] lk_wr_sector,
    input  logic                   lk_wr_lock,
    input  logic                   lk_wr_down,
    input  logic                   clr_flags,
    output logic                   op_allow,
    output logic                   op_deny,
    output logic                   prot_err
);
    import wpc_pkg::*;

    localparam int OFFS_W = ADDR_W - SECTOR_BITS;

    typedef struct packed {
        logic [BP_W-1:0] bp;
        logic            tb;
        logic            srwd;
        logic            allow;
        logic            deny;
        logic            err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SECTOR_BITS-1:0] sector;
    logic [OFFS_W-1:0]      unused_offset;
    logic                   sec_range, any_range;
    logic                   sec_lock, any_lock;
    logic                   sr_blocked, blocked;
    wpc_op_e                kind;

    assign sector        = op_addr[ADDR_W-1 -: SECTOR_BITS];
    assign unused_offset = op_addr[OFFS_W-1:0];
    assign kind          = wpc_op_e'(op_kind);

    wpc_range #(.SECTOR_BITS(SECTOR_BITS), .BP_W(BP_W)) u_range (
        .bp        (ctl_q.bp),
        .tb        (ctl_q.tb),
        .sector    (sector),
        .in_range  (sec_range),
        .any_range (any_range)
    );

    wpc_lock_bank #(.SECTOR_BITS(SECTOR_BITS)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lk_wr_en),
        .wr_sector (lk_wr_sector),
        .wr_lock   (lk_wr_lock),
        .wr_down   (lk_wr_down),
        .rd_sector (sector),
        .rd_lock   (sec_lock),
        .any_lock  (any_lock)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.allow = 1'b0;
        ctl_d.deny  = 1'b0;
        sr_blocked  = ctl_q.srwd && !wp_n;
        blocked     = (kind == OP_BULK) ? (any_range || any_lock)
                                        : (sec_range || sec_lock);
        if (sr_wr_en && !sr_blocked) begin
            ctl_d.bp   = sr_wr_bp;
            ctl_d.tb   = sr_wr_tb;
            ctl_d.srwd = sr_wr_srwd;
        end
        if (op_valid) begin
            ctl_d.allow = !blocked;
            ctl_d.deny  = blocked;
        end
        if (clr_flags)  ctl_d.err = 1'b0;
        if (ctl_d.deny) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign op_allow = ctl_q.allow;
    assign op_deny  = ctl_q.deny;
    assign prot_err = ctl_q.err;

    // R9: a request gets exactly one verdict in the next cycle
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (op_allow ^ op_deny));

    // R9: no verdict without a request
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !(op_allow || op_deny));

    // R8: a deny is always accompanied by the flag
    p_deny_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_deny |-> prot_err);

    // R8: the flag drops only after a clear
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_err) |-> $past(clr_flags));

    // R6: a pin-frozen status register keeps its protect settings
    p_sr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && ctl_q.srwd && !wp_n) |=> ($stable(ctl_q.bp) && $stable(ctl_q.tb)));
endmodule

// File: tb/sector_wp_checker_bench.sv
`timescale 1ns/1ps
module sector_wp_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [23:0] op_addr = '0;
    logic        sr_wr_en = 1'b0;
    logic [3:0]  sr_wr_bp = '0;
    logic        sr_wr_tb = 1'b0;
    logic        sr_wr_srwd = 1'b0;
    logic        wp_n = 1'b1;
    logic        lk_wr_en = 1'b0;
    logic [7:0]  lk_wr_sector = '0;
    logic        lk_wr_lock = 1'b0;
    logic        lk_wr_down = 1'b0;
    logic        clr_flags = 1'b0;
    logic        op_allow, op_deny, prot_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sector_wp_checker u_sector_wp_checker (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .sr_wr_en(sr_wr_en), .sr_wr_bp(sr_wr_bp),
        .sr_wr_tb(sr_wr_tb), .sr_wr_srwd(sr_wr_srwd), .wp_n(wp_n),
        .lk_wr_en(lk_wr_en), .lk_wr_sector(lk_wr_sector), .lk_wr_lock(lk_wr_lock),
        .lk_wr_down(lk_wr_down), .clr_flags(clr_flags),
        .op_allow(op_allow), .op_deny(op_deny), .prot_err(prot_err)
    );

    // entry: [15:12] protect value, [11] top/bottom, [10:9] kind, [8:1] sector, [0] expect allow
    localparam logic [15:0] VEC [16] = '{
        {4'd0,  1'b1, 2'd0, 8'd0,   1'b1},   // R1
        {4'd1,  1'b1, 2'd0, 8'd0,   1'b0},   // R2
        {4'd1,  1'b1, 2'd1, 8'd1,   1'b1},   // R2
        {4'd2,  1'b1, 2'd0, 8'd1,   1'b0},   // R2
        {4'd2,  1'b1, 2'd2, 8'd2,   1'b1},   // R2
        {4'd8,  1'b1, 2'd0, 8'd127, 1'b0},   // R2
        {4'd8,  1'b1, 2'd0, 8'd128, 1'b1},   // R2
        {4'd9,  1'b1, 2'd1, 8'd255, 1'b0},   // R2
        {4'd15, 1'b0, 2'd0, 8'd0,   1'b0},   // R3
        {4'd1,  1'b0, 2'd0, 8'd255, 1'b0},   // R3
        {4'd1,  1'b0, 2'd2, 8'd254, 1'b1},   // R3
        {4'd3,  1'b0, 2'd0, 8'd252, 1'b0},   // R3
        {4'd3,  1'b0, 2'd0, 8'd251, 1'b1},   // R3
        {4'd0,  1'b0, 2'd3, 8'd0,   1'b1},   // R7
        {4'd1,  1'b0, 2'd3, 8'd0,   1'b0},   // R7
        {4'd2,  1'b1, 2'd2, 8'd3,   1'b1}    // R2
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sr_write(input logic [3:0] bp, input logic tb, input logic srwd);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_bp = bp; sr_wr_tb = tb; sr_wr_srwd = srwd;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic lk_write(input logic [7:0] sec, input logic lk, input logic dn);
        @(negedge clk);
        lk_wr_en = 1'b1; lk_wr_sector = sec; lk_wr_lock = lk; lk_wr_down = dn;
        @(negedge clk);
        lk_wr_en = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    // drives one request and checks the verdict at the following negedge
    task automatic op_check(input string tag, input logic [1:0] kind,
                            input logic [7:0] sec, input logic exp_allow);
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_addr = {sec, 16'h5A3C};
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, {op_allow, op_deny}, exp_allow ? 2 : 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 outputs after reset", {op_allow, op_deny, prot_err}, 0);
        op_check("R10 no protection after reset", 2'd2, 8'd255, 1'b1);
        @(negedge clk);
        check("R9 idle verdict clear", {op_allow, op_deny}, 0);

        // table walk
        for (int i = 0; i < 16; i++) begin
            sr_write(VEC[i][15:12], VEC[i][11], 1'b0);
            op_check($sformatf("R2/R3/R7 vector %0d", i), VEC[i][10:9], VEC[i][8:1], VEC[i][0]);
        end

        // R8: sticky error flag
        clear_err();
        check("R8 cleared", prot_err, 0);
        sr_write(4'd1, 1'b1, 1'b0);
        op_check("R8 deny", 2'd0, 8'd0, 1'b0);
        check("R8 flag set", prot_err, 1);
        op_check("R8 allow keeps", 2'd0, 8'd9, 1'b1);
        check("R8 flag held", prot_err, 1);
        // deny and clear together: set wins
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd0; op_addr = 24'h000000; clr_flags = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; clr_flags = 1'b0;
        check("R8 set beats clear", prot_err, 1);
        clear_err();
        check("R8 flag cleared", prot_err, 0);

        // R4: lock bits
        sr_write(4'd0, 1'b0, 1'b0);
        lk_write(8'd5, 1'b1, 1'b0);
        op_check("R4 locked program", 2'd0, 8'd5, 1'b0);
        op_check("R4 locked subsector erase", 2'd1, 8'd5, 1'b0);
        op_check("R4 neighbour free", 2'd0, 8'd6, 1'b1);
        lk_write(8'd5, 1'b0, 1'b0);
        op_check("R4 unlocked", 2'd2, 8'd5, 1'b1);

        // R7: bulk blocked by a lock alone
        lk_write(8'd200, 1'b1, 1'b0);
        op_check("R7 bulk vs lock", 2'd3, 8'd0, 1'b0);
        lk_write(8'd200, 1'b0, 1'b0);
        op_check("R7 bulk free", 2'd3, 8'd0, 1'b1);

        // R5: lock-down freezes
        lk_write(8'd255, 1'b1, 1'b1);
        lk_write(8'd255, 1'b0, 1'b0);
        op_check("R5 lock frozen", 2'd0, 8'd255, 1'b0);
        lk_write(8'd255, 1'b0, 1'b0);
        op_check("R5 down not clearable", 2'd2, 8'd255, 1'b0);
        // R9: same-cycle write not seen by request
        @(negedge clk);
        lk_wr_en = 1'b1; lk_wr_sector = 8'd40; lk_wr_lock = 1'b1; lk_wr_down = 1'b0;
        op_valid = 1'b1; op_kind = 2'd0; op_addr = {8'd40, 16'h0};
        @(negedge clk);
        lk_wr_en = 1'b0; op_valid = 1'b0;
        check("R9 old state used", op_allow, 1);
        op_check("R4 lock now active", 2'd0, 8'd40, 1'b0);
        do_reset();
        op_check("R10 locks cleared", 2'd0, 8'd255, 1'b1);
        op_check("R10 lock 40 cleared", 2'd0, 8'd40, 1'b1);
        check("R10 flag cleared", prot_err, 0);

        // R6: write-protect pin
        wp_n = 1'b0;
        sr_write(4'd0, 1'b1, 1'b1);      // srwd was 0: accepted
        sr_write(4'd9, 1'b1, 1'b1);      // frozen
        op_check("R6 frozen write ignored", 2'd0, 8'd0, 1'b1);
        wp_n = 1'b1;
        sr_write(4'd9, 1'b1, 1'b1);
        op_check("R6 pin high write taken", 2'd0, 8'd0, 1'b0);
        wp_n = 1'b0;
        sr_write(4'd0, 1'b1, 1'b0);
        op_check("R6 unprotect refused", 2'd0, 8'd128, 1'b0);
        wp_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule